// File: doc/BRIEF.md
# OTG Cable-State Session Controller

This block watches the raw cable ID and VBUS sense inputs of a dual-role USB port. It filters their changes through a restartable settle timer, works out the effective ID and VBUS levels from the configured role and from which detectors the board actually has, and drives the override fields of the port's interface status/control word. The host or the device controller is then chosen from the resolved ID. Periodic rescans are available for boards whose sense lines cannot be trusted to produce edges.

When the port changes role, a session end can be forced by holding the VBUS-valid override low. The hold is short when the port enters host role and happens before the new ID is written. The hold is long when the port enters device role and happens after the new ID is written. Single-cycle `host_changed` and `vbus_changed` strobes tell the rest of the chip that a new state has been applied. All time constants are parameters counted in clock cycles.

FSM states: `ST_IDLE` waits for a pending scan while the port is up. `ST_EVAL` samples the effective levels and decides the path. `ST_HOST_END` holds VBUS low before a host-role ID update. `ST_ID_APPLY` writes the ID override, route and bypass. `ST_DEV_END` holds VBUS low after a device-role ID update. `ST_VBUS` writes the VBUS override. The transitions are: idle→eval when a scan is pending; eval→host_end when the ID changes to 0 with a session end due; eval→id_apply when the ID changes otherwise; eval→vbus when the ID is unchanged; host_end→id_apply when the hold is done; id_apply→dev_end when the ID is 1 with a session end due, otherwise id_apply→vbus; dev_end→vbus when the hold is done; vbus→idle always. A port init or shutdown pulse returns any state to idle.

Top module: `otg_session_ctrl`

## Requirements
- R1: After reset, `isc_ctl`, `route_dev` and `bypass_en` are all 0. A `port_init` pulse sets the ID pull-up enable (`isc_ctl[17]`) and the DP/DM pull-up enable (`isc_ctl[16]`). A `port_shutdown` pulse clears both.
- R2: The ID override is `isc_ctl[15:14]` and the VBUS override is `isc_ctl[13:12]`. In each field, 2'b10 forces the level low and 2'b11 forces it high.
- R3: An edge on the synchronised ID or VBUS input, or a `vbus_en_req` pulse, restarts a settle timer of DEB_CYC cycles. A scan follows only when that timer expires, so a change is applied no sooner than DEB_CYC cycles after the last edge and no later than DEB_CYC+12 cycles after it.
- R4: While `poll_en` is 1 and the port is up, a scan runs every POLL_CYC cycles even if the inputs keep moving. While `poll_en` is 0, a constantly moving input produces no scan.
- R5: `mode_sel` is latched on `mode_set`, with 2'b00 meaning OTG, 2'b01 meaning host and 2'b10 meaning device. Host gives an effective ID of 0 and device gives 1. OTG uses `id_pin` when `has_id_det` is 1 and uses 1 otherwise. The effective VBUS is 1 when `has_vbus_det` is 0.
- R6: On a change to ID 0 with a session end due, the VBUS override is 2'b10 for exactly HOST_END_CYC cycles and then 2'b11. The ID override is written only after that.
- R7: On a change to ID 1 with a session end due, the ID override is written first. The VBUS override then reads 2'b10 for exactly DEV_END_CYC cycles and then 2'b11.
- R8: A session end is due after any `mode_set`, and on any ID change in OTG role while `has_vbus_det` is 0. An ID change in OTG role with `has_vbus_det` at 1 causes no VBUS low hold.
- R9: Each ID update sets `route_dev` to the new ID (0 selects the host controller, 1 the device controller) and sets `bypass_en` to its inverse.
- R10: `port_init` and `mode_set` mark the stored ID as unknown, so the next scan rewrites it and pulses `host_changed` even when the level is the same. `port_init` also marks the stored VBUS as unknown.
- R11: `host_changed` and `vbus_changed` each last one cycle. `vbus_changed` fires only when the applied VBUS level differs from the stored one or the stored one is unknown.
- R12: While the port is not initialised, no scan runs, so neither override changes and no strobe is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_init | input | 1 | Pulse: bring the port up |
| port_shutdown | input | 1 | Pulse: take the port down |
| mode_set | input | 1 | Pulse: latch `mode_sel` and request a session end |
| mode_sel | input | 2 | Role: 00 OTG, 01 host, 10 device |
| id_pin | input | 1 | Raw ID sense, asynchronous |
| vbus_pin | input | 1 | Raw VBUS sense, asynchronous |
| has_id_det | input | 1 | Board strap: an ID detector is present |
| has_vbus_det | input | 1 | Board strap: a VBUS detector is present |
| poll_en | input | 1 | Enable the periodic rescan |
| vbus_en_req | input | 1 | Pulse: VBUS drive was requested, restart the settle timer |
| isc_ctl | output | 6 | Bits 17:12 of the status/control word: pull-ups and overrides |
| route_dev | output | 1 | 1 routes the port to the device controller |
| bypass_en | output | 1 | Host-side bypass enables |
| host_changed | output | 1 | One-cycle strobe after an ID update |
| vbus_changed | output | 1 | One-cycle strobe after a VBUS level change |

## Verification
A stored level that is wrong or stuck shows up at the override fields and at the strobes on the next scan, no more than DEB_CYC plus a few cycles after an input edge. A wrong hold counter or a wrong ordering shows up as a VBUS low window of the wrong length, or as an ID write on the wrong side of that window, within one hold time of the role change. A settle timer that does not restart moves the strobe earlier by the length of the glitch train. A lost unknown mark shows up as a missing `host_changed` after init or after a mode change.

// File: rtl/otg_sess_pkg.sv
package otg_sess_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_HOST_END,
        ST_ID_APPLY,
        ST_DEV_END,
        ST_VBUS
    } sess_state_t;

    localparam logic [1:0] ROLE_OTG  = 2'b00;
    localparam logic [1:0] ROLE_HOST = 2'b01;

    localparam logic [1:0] FORCE_LO = 2'b10;
    localparam logic [1:0] FORCE_HI = 2'b11;

endpackage

// File: rtl/otg_sync.sv
module otg_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] synced
);
    logic [W-1:0] meta;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta[b]   <= 1'b0;
                synced[b] <= 1'b0;
            end else begin
                meta[b]   <= raw[b];
                synced[b] <= meta[b];
            end
        end
    end
endmodule

// File: rtl/otg_scan_timer.sv
module otg_scan_timer #(
    parameter int DEB_CYC  = 6_250_000,
    parameter int POLL_CYC = 31_250_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sig_s,
    input  logic       restart,
    input  logic       poll_on,
    output logic       scan_tick
);
    localparam int DW = $clog2(DEB_CYC + 1);
    localparam int PW = $clog2(POLL_CYC + 1);

    logic [1:0]    sig_d;
    logic          deb_act;
    logic [DW-1:0] deb_cnt;
    logic [PW-1:0] poll_cnt;
    logic          edge_seen;

    assign edge_seen = (sig_s != sig_d) | restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sig_d     <= '0;
            deb_act   <= 1'b0;
            deb_cnt   <= '0;
            poll_cnt  <= '0;
            scan_tick <= 1'b0;
        end else begin
            sig_d     <= sig_s;
            scan_tick <= 1'b0;
            if (edge_seen) begin
                deb_act <= 1'b1;
                deb_cnt <= '0;
            end else if (deb_act) begin
                if (deb_cnt == DW'(DEB_CYC - 1)) begin
                    deb_act   <= 1'b0;
                    scan_tick <= 1'b1;
                end else begin
                    deb_cnt <= deb_cnt + 1'b1;
                end
            end
            if (poll_on) begin
                if (poll_cnt == PW'(POLL_CYC - 1)) begin
                    poll_cnt  <= '0;
                    scan_tick <= 1'b1;
                end else begin
                    poll_cnt <= poll_cnt + 1'b1;
                end
            end else begin
                poll_cnt <= '0;
            end
        end
    end

    // R3
    deb_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deb_cnt < DW'(DEB_CYC));

    // R3
    deb_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (deb_act && deb_cnt == '0 && !(scan_tick && !poll_on)));
endmodule

// File: rtl/otg_session_ctrl.sv
module otg_session_ctrl
    import otg_sess_pkg::*;
#(
    parameter int DEB_CYC      = 6_250_000,
    parameter int POLL_CYC     = 31_250_000,
    parameter int HOST_END_CYC = 25_000_000,
    parameter int DEV_END_CYC  = 125_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_init,
    input  logic        port_shutdown,
    input  logic        mode_set,
    input  logic [1:0]  mode_sel,
    input  logic        id_pin,
    input  logic        vbus_pin,
    input  logic        has_id_det,
    input  logic        has_vbus_det,
    input  logic        poll_en,
    input  logic        vbus_en_req,
    output logic [17:12] isc_ctl,
    output logic        route_dev,
    output logic        bypass_en,
    output logic        host_changed,
    output logic        vbus_changed
);
    localparam int HOLD_MAX = (HOST_END_CYC > DEV_END_CYC) ? HOST_END_CYC : DEV_END_CYC;
    localparam int HW       = $clog2(HOLD_MAX + 1);

    sess_state_t state_q, state_d;

    logic [1:0]    sync_s;
    logic          scan_tick;
    logic          up_q, scan_pend;
    logic [1:0]    mode_q;
    logic [1:0]    pu_q, force_id_q, force_vbus_q;
    logic          id_q, id_known, vbus_q, vbus_known;
    logic          force_end_q, end_q, new_id, new_vbus;
    logic [HW-1:0] hold_cnt;
    logic          eff_id, eff_vbus, fe, id_diff, host_done, dev_done;

    otg_sync #(.W(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({id_pin, vbus_pin}),
        .synced (sync_s)
    );

    otg_scan_timer #(.DEB_CYC(DEB_CYC), .POLL_CYC(POLL_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_s     (sync_s),
        .restart   (vbus_en_req),
        .poll_on   (poll_en & up_q),
        .scan_tick (scan_tick)
    );

    always_comb begin
        unique case (mode_q)
            ROLE_HOST: eff_id = 1'b0;
            ROLE_OTG:  eff_id = has_id_det ? sync_s[1] : 1'b1;
            default:   eff_id = 1'b1;
        endcase
        eff_vbus  = has_vbus_det ? sync_s[0] : 1'b1;
        fe        = force_end_q | ((mode_q == ROLE_OTG) & ~has_vbus_det);
        id_diff   = ~id_known | (eff_id != id_q);
        host_done = (hold_cnt == HW'(HOST_END_CYC - 1));
        dev_done  = (hold_cnt == HW'(DEV_END_CYC - 1));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (scan_pend && up_q) state_d = ST_EVAL;
            ST_EVAL:     state_d = !id_diff ? ST_VBUS :
                                   (fe && !eff_id) ? ST_HOST_END : ST_ID_APPLY;
            ST_HOST_END: if (host_done) state_d = ST_ID_APPLY;
            ST_ID_APPLY: state_d = (end_q && new_id) ? ST_DEV_END : ST_VBUS;
            ST_DEV_END:  if (dev_done) state_d = ST_VBUS;
            ST_VBUS:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else if (port_init || port_shutdown) state_q <= ST_IDLE;
        else state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            up_q <= 1'b0; scan_pend <= 1'b0; mode_q <= ROLE_OTG;
            pu_q <= 2'b00; force_id_q <= 2'b00; force_vbus_q <= 2'b00;
            id_q <= 1'b0; id_known <= 1'b0; vbus_q <= 1'b0; vbus_known <= 1'b0;
            force_end_q <= 1'b0; end_q <= 1'b0; new_id <= 1'b0; new_vbus <= 1'b0;
            hold_cnt <= '0; route_dev <= 1'b0; bypass_en <= 1'b0;
            host_changed <= 1'b0; vbus_changed <= 1'b0;
        end else begin
            host_changed <= 1'b0;
            vbus_changed <= 1'b0;
            unique case (state_q)
                ST_EVAL: begin
                    new_id      <= eff_id;
                    new_vbus    <= eff_vbus;
                    end_q       <= fe;
                    force_end_q <= 1'b0;
                    scan_pend   <= 1'b0;
                    hold_cnt    <= '0;
                    if (id_diff && fe && !eff_id) force_vbus_q <= FORCE_LO;
                end
                ST_HOST_END: begin
                    hold_cnt <= hold_cnt + 1'b1;
                    if (host_done) force_vbus_q <= FORCE_HI;
                end
                ST_ID_APPLY: begin
                    force_id_q   <= new_id ? FORCE_HI : FORCE_LO;
                    id_q         <= new_id;
                    id_known     <= 1'b1;
                    route_dev    <= new_id;
                    bypass_en    <= ~new_id;
                    host_changed <= 1'b1;
                    hold_cnt     <= '0;
                    if (end_q && new_id) force_vbus_q <= FORCE_LO;
                end
                ST_DEV_END: begin
                    hold_cnt <= hold_cnt + 1'b1;
                    if (dev_done) force_vbus_q <= FORCE_HI;
                end
                ST_VBUS: begin
                    force_vbus_q <= new_vbus ? FORCE_HI : FORCE_LO;
                    if (!vbus_known || new_vbus != vbus_q) vbus_changed <= 1'b1;
                    vbus_q     <= new_vbus;
                    vbus_known <= 1'b1;
                end
                default: ;
            endcase
            if (scan_tick) scan_pend <= 1'b1;
            if (mode_set) begin
                mode_q      <= mode_sel;
                id_known    <= 1'b0;
                force_end_q <= 1'b1;
                scan_pend   <= 1'b1;
            end
            if (port_init) begin
                pu_q       <= 2'b11;
                up_q       <= 1'b1;
                id_known   <= 1'b0;
                vbus_known <= 1'b0;
                scan_pend  <= 1'b1;
            end
            if (port_shutdown) begin
                pu_q      <= 2'b00;
                up_q      <= 1'b0;
                scan_pend <= 1'b0;
            end
        end
    end

    assign isc_ctl = {pu_q, force_id_q, force_vbus_q};

    // R11
    host_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_changed |=> !host_changed);

    // R11
    vbus_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vbus_changed |=> !vbus_changed);

    // R6
    host_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOST_END) |-> (isc_ctl[13:12] == FORCE_LO));

    // R7
    dev_end_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_END) |-> (isc_ctl[13:12] == FORCE_LO && isc_ctl[15:14] == FORCE_HI));

    // R1
    shutdown_pullup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_shutdown |=> (isc_ctl[17:16] == 2'b00));

    // R9
    route_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_changed |-> (route_dev != bypass_en));

    // R12
    idle_when_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !up_q |-> (state_q == ST_IDLE && !host_changed));
endmodule

// File: tb/otg_session_ctrl_test.sv
module otg_session_ctrl_test;
    localparam int DEB  = 40;
    localparam int POLL = 300;
    localparam int HEND = 20;
    localparam int DEND = 60;

    logic clk = 1'b0, rst_n = 1'b0;
    logic port_init = 0, port_shutdown = 0, mode_set = 0;
    logic [1:0] mode_sel = 2'b00;
    logic id_pin = 1, vbus_pin = 0, has_id_det = 1, has_vbus_det = 1;
    logic poll_en = 0, vbus_en_req = 0;
    logic [17:12] isc_ctl;
    logic route_dev, bypass_en, host_changed, vbus_changed;

    otg_session_ctrl #(.DEB_CYC(DEB), .POLL_CYC(POLL), .HOST_END_CYC(HEND), .DEV_END_CYC(DEND)) uut (
        .clk(clk), .rst_n(rst_n), .port_init(port_init), .port_shutdown(port_shutdown),
        .mode_set(mode_set), .mode_sel(mode_sel), .id_pin(id_pin), .vbus_pin(vbus_pin),
        .has_id_det(has_id_det), .has_vbus_det(has_vbus_det), .poll_en(poll_en),
        .vbus_en_req(vbus_en_req), .isc_ctl(isc_ctl), .route_dev(route_dev),
        .bypass_en(bypass_en), .host_changed(host_changed), .vbus_changed(vbus_changed)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;
    int cyc = 0, host_cnt = 0, vbus_cnt = 0, last_vbus_pulse = 0;
    int last_id_chg = 0, win_start = 0, win_end = 0, win_len = 0, win_cnt = 0;
    bit in_win = 0, prev_hc = 0, prev_vc = 0;
    logic [1:0] prev_fv = 2'b00, prev_fid = 2'b00, exp_pu = 2'b00;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // behavioural model of the pull-up enables
    always @(posedge clk) begin
        if (!rst_n) exp_pu <= 2'b00;
        else if (port_shutdown) exp_pu <= 2'b00;
        else if (port_init) exp_pu <= 2'b11;
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(isc_ctl[17:16] == exp_pu, "R1 pull-ups", isc_ctl[17:16], exp_pu);
            if (host_changed && prev_hc) check(0, "R11 host strobe width", 2, 1);
            if (vbus_changed && prev_vc) check(0, "R11 vbus strobe width", 2, 1);
        end
        if (host_changed) host_cnt++;
        if (vbus_changed) begin vbus_cnt++; last_vbus_pulse = cyc; end
        if (isc_ctl[15:14] != prev_fid) last_id_chg = cyc;
        if (isc_ctl[13:12] == 2'b10 && prev_fv == 2'b11) begin win_start = cyc; in_win = 1; end
        if (in_win && isc_ctl[13:12] == 2'b11 && prev_fv == 2'b10) begin
            win_end = cyc; win_len = cyc - win_start; win_cnt++; in_win = 0;
        end
        prev_fid = isc_ctl[15:14];
        prev_fv  = isc_ctl[13:12];
        prev_hc  = host_changed;
        prev_vc  = vbus_changed;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_init();
        @(negedge clk) port_init = 1;
        @(negedge clk) port_init = 0;
    endtask

    task automatic do_mode(input logic [1:0] m);
        @(negedge clk) begin mode_sel = m; mode_set = 1; end
        @(negedge clk) mode_set = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int t0, hc, vc, w0;
        tick(3);
        // R1 reset state
        check(isc_ctl == 6'b0, "R1 reset ctl", isc_ctl, 0);
        check(route_dev == 0 && bypass_en == 0, "R1 reset route/bypass", {route_dev, bypass_en}, 0);
        @(negedge clk) rst_n = 1;
        tick(5);
        // R12 nothing happens before init
        check(host_cnt == 0 && isc_ctl[15:12] == 0, "R12 idle before init", isc_ctl[15:12], 0);

        // init: OTG, id pin 1, vbus 0
        do_init();
        tick(12);
        check(isc_ctl[17:16] == 2'b11, "R1 init pull-ups", isc_ctl[17:16], 3);
        check(isc_ctl[15:14] == 2'b11, "R2 id forced high", isc_ctl[15:14], 3);
        check(isc_ctl[13:12] == 2'b10, "R2 vbus forced low", isc_ctl[13:12], 2);
        check(route_dev == 1 && bypass_en == 0, "R9 device route", {route_dev, bypass_en}, 2);
        check(host_cnt == 1, "R10 init reapplies id", host_cnt, 1);
        check(vbus_cnt == 1, "R11 init vbus strobe", vbus_cnt, 1);
        tick(DEB + 20);

        // R3 settle latency
        @(negedge clk) begin vbus_pin = 1; t0 = cyc; end
        vc = vbus_cnt;
        for (int i = 0; i < DEB + 30 && vbus_cnt == vc; i++) tick(1);
        check(last_vbus_pulse - t0 >= DEB && last_vbus_pulse - t0 <= DEB + 12,
              "R3 settle latency", last_vbus_pulse - t0, DEB);
        check(isc_ctl[13:12] == 2'b11, "R2 vbus forced high", isc_ctl[13:12], 3);

        // R3 restart on every edge
        tick(5);
        vc = vbus_cnt;
        @(negedge clk) begin vbus_pin = 0; t0 = cyc; end
        tick(30); vbus_pin = 1;
        tick(30); vbus_pin = 0;
        for (int i = 0; i < DEB + 30 && vbus_cnt == vc; i++) tick(1);
        check(vbus_cnt == vc + 1, "R3 single scan after glitches", vbus_cnt - vc, 1);
        check(last_vbus_pulse - t0 >= 60 + DEB && last_vbus_pulse - t0 <= 72 + DEB,
              "R3 timer restarted", last_vbus_pulse - t0, 60 + DEB);
        vbus_pin = 1;
        tick(DEB + 20);

        // R8 OTG with vbus detector: id change, no session end
        w0 = win_cnt; hc = host_cnt;
        id_pin = 0;
        tick(DEB + 30);
        check(isc_ctl[15:14] == 2'b10, "R5 otg id from pin", isc_ctl[15:14], 2);
        check(route_dev == 0 && bypass_en == 1, "R9 host route", {route_dev, bypass_en}, 1);
        check(win_cnt == w0 && host_cnt == hc + 1, "R8 no session end", win_cnt - w0, 0);
        id_pin = 1;
        tick(DEB + 30);
        check(isc_ctl[15:14] == 2'b11 && route_dev == 1, "R9 back to device", isc_ctl[15:14], 3);
        check(win_cnt == w0, "R8 no session end back", win_cnt - w0, 0);

        // R6 host mode via mode change, pin still 1
        w0 = win_cnt;
        do_mode(2'b01);
        tick(HEND + DEND + 30);
        check(isc_ctl[15:14] == 2'b10, "R5 host role forces id 0", isc_ctl[15:14], 2);
        check(win_cnt == w0 + 1, "R8 mode change ends session", win_cnt - w0, 1);
        check(win_len == HEND, "R6 host hold length", win_len, HEND);
        check(last_id_chg > win_end, "R6 id after hold", last_id_chg, win_end + 1);

        // R7 device mode
        w0 = win_cnt;
        do_mode(2'b10);
        tick(HEND + DEND + 30);
        check(isc_ctl[15:14] == 2'b11, "R5 device role forces id 1", isc_ctl[15:14], 3);
        check(win_cnt == w0 + 1, "R7 session end", win_cnt - w0, 1);
        check(win_len == DEND, "R7 device hold length", win_len, DEND);
        check(last_id_chg <= win_start, "R7 id before hold", last_id_chg, win_start);

        // R8 OTG without vbus detector: id change ends session
        has_vbus_det = 0;
        hc = host_cnt;
        do_mode(2'b00);
        tick(HEND + DEND + 30);
        check(host_cnt == hc + 1, "R10 mode change reapplies id", host_cnt - hc, 1);
        w0 = win_cnt;
        id_pin = 0;
        tick(DEB + HEND + 40);
        check(win_cnt == w0 + 1 && win_len == HEND, "R8 id change ends session", win_len, HEND);
        check(isc_ctl[15:14] == 2'b10, "R8 id applied", isc_ctl[15:14], 2);
        vc = vbus_cnt;
        vbus_pin = 0;
        tick(DEB + 30);
        check(isc_ctl[13:12] == 2'b11 && vbus_cnt == vc, "R5 vbus default high", isc_ctl[13:12], 3);

        // R5 OTG without id detector
        has_id_det = 0;
        do_mode(2'b00);
        tick(HEND + DEND + 30);
        check(isc_ctl[15:14] == 2'b11, "R5 otg id default 1", isc_ctl[15:14], 3);

        // R4 polling
        has_vbus_det = 1;
        vc = vbus_cnt;
        for (int i = 0; i < 1800 / 8; i++) begin vbus_pin = ~vbus_pin; tick(8); end
        check(vbus_cnt == vc, "R4 no scan without poll", vbus_cnt - vc, 0);
        poll_en = 1;
        vc = vbus_cnt;
        for (int i = 0; i < 1800 / 8; i++) begin vbus_pin = ~vbus_pin; tick(8); end
        check(vbus_cnt > vc, "R4 poll scans", vbus_cnt - vc, 1);
        poll_en = 0;
        tick(DEB + 30);

        // R12 shutdown: scans ignored
        @(negedge clk) port_shutdown = 1;
        @(negedge clk) port_shutdown = 0;
        tick(2);
        check(isc_ctl[17:16] == 2'b00, "R1 shutdown pull-ups", isc_ctl[17:16], 0);
        has_id_det = 1;
        hc = host_cnt;
        @(negedge clk) vbus_en_req = 1;
        @(negedge clk) vbus_en_req = 0;
        tick(DEB + 30);
        check(host_cnt == hc && isc_ctl[15:14] == 2'b11, "R12 no scan while down", host_cnt - hc, 0);

        // R10 re-init reapplies id
        do_init();
        tick(HEND + 30);
        check(host_cnt == hc + 1, "R10 reinit strobe", host_cnt - hc, 1);
        check(isc_ctl[15:14] == 2'b10, "R10 reinit id from pin", isc_ctl[15:14], 2);

        finished = 1;
        summary();
        $finish;
    end
endmodule